// File: doc/BRIEF.md
# Poly1305 Tag Engine with Squared-Key Lane Interleave

The engine produces a 128-bit Poly1305 authenticator for one message at a time using a single multicycle multiplier over the prime 2^130-5. A packet enters as a stream of 128-bit words on a valid/ready handshake. The first word carries the key half r, which the engine clamps and squares at once. The second word carries the pad half s. Every later word is one 16-byte message block. The block flagged as last may be shorter, with its valid byte count given beside it.

Message blocks are written alternately into two small lane FIFOs, so they can arrive at one per cycle while r^2 is still being formed. Each lane keeps its own accumulator and advances by adding a block and multiplying by r^2. The one block that ends the message is multiplied by r instead. This leaves the two lane sums weighted by r^2 and r, so their sum equals the serial Horner result. That sum plus s, truncated to 128 bits, is presented for one cycle. The engine then accepts the next packet with both accumulators cleared.

Top module: `poly_tag_engine`

## Requirements
- R1: After reset, in_ready is high and tag_valid is low.
- R2: The first word accepted in a packet is r. Bits 31:28, 63:60, 95:92, 127:124, 33:32, 65:64 and 97:96 of that word are cleared before use, so their values have no effect on the tag.
- R3: The second word accepted is s. Each later word is a message block m_i with bit 128 set as its pad. The tag is ((sum of m_i * r^(n-i+1)) mod 2^130-5, plus s) mod 2^128, for any block count n of one or more.
- R4: On the word with in_last set, in_bytes = k with 1 <= k <= 15 keeps bytes 0..k-1 (byte j is bits 8j+7:8j), zeroes the rest, and sets bit 8k as the pad. in_bytes of 16 or 0 marks a full block.
- R5: in_bytes has no effect on words that do not carry in_last.
- R6: From the cycle after the last word is accepted until tag_valid, in_ready is low. tag_valid is high for exactly one cycle, with in_ready already high in that cycle. The next packet starts with cleared state.
- R7: Words are accepted on back-to-back cycles while the lane FIFO being written has room. When the message outpaces the multiplier, in_ready drops and no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word on in_data is offered |
| in_ready | output | 1 | Engine accepts the offered word this cycle |
| in_data | input | 128 | r, s, or a message block, little-endian bytes |
| in_last | input | 1 | This message word ends the packet |
| in_bytes | input | 5 | Valid bytes in the last word (1..16, 0 means 16) |
| tag_valid | output | 1 | One-cycle strobe for tag |
| tag | output | 128 | Authenticator (h + s) mod 2^128 |

## Verification
Any error in the clamp, the pad position, lane steering or the choice between r and r^2 corrupts the tag. The wrong tag shows at the tag_valid strobe of the packet that caused it. A stale accumulator, or an r^2 left over from the previous packet, shows only in the following packet's tag, so packets are run back to back with different keys. Handshake faults, such as a lost word under FIFO backpressure or in_ready reopening early, show either within a cycle of the last word or as a wrong tag.

// File: rtl/poly_pkg.sv
package poly_pkg;

   localparam int FE_W  = 130;
   localparam int BLK_W = 129;

   typedef logic [FE_W-1:0] fe_t;

   typedef enum logic [1:0] {
      PH_R      = 2'd0,
      PH_S      = 2'd1,
      PH_MSG    = 2'd2,
      PH_CLOSED = 2'd3
   } phase_e;

   // 2^130 - 5
   localparam fe_t P_MOD = {2'b11, {124{1'b1}}, 4'b1011};

   localparam logic [127:0] R_CLAMP = 128'h0ffffffc0ffffffc0ffffffc0fffffff;

   // one conditional subtraction; valid for inputs below 2*P_MOD
   function automatic fe_t red_once(input logic [FE_W:0] x);
      logic [FE_W:0] d;
      d = x - {1'b0, P_MOD};
      return (x >= {1'b0, P_MOD}) ? d[FE_W-1:0] : x[FE_W-1:0];
   endfunction

   // keep n low bytes and place the pad bit at 8n (n = 0 or >15 -> full block)
   function automatic logic [BLK_W-1:0] pad_block(input logic [127:0] data,
                                                  input logic [4:0]   nbytes);
      logic [BLK_W-1:0] blk;
      int unsigned      n;
      n   = (nbytes == 5'd0 || nbytes > 5'd16) ? 16 : int'(nbytes);
      blk = '0;
      for (int j = 0; j < 16; j++) begin
         if (j < n) blk[8*j +: 8] = data[8*j +: 8];
      end
      blk[8*n] = 1'b1;
      return blk;
   endfunction

endpackage

// File: rtl/poly_lane_fifo.sv
module poly_lane_fifo #(
   parameter int W     = 130,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign rdata = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push && !full) wp_q <= wp_q + 1'b1;
         if (pop && !empty) rp_q <= rp_q + 1'b1;
         case ({push && !full, pop && !empty})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/poly_modmul.sv
module poly_modmul import poly_pkg::*; #(
   parameter int DIGIT_W = 26
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [FE_W:0] a,
   input  fe_t         b,
   output logic        busy,
   output logic        done,
   output fe_t         y
);
   localparam int NDIG = (FE_W + DIGIT_W - 1) / DIGIT_W;
   localparam int BW   = NDIG * DIGIT_W;
   localparam int WX   = FE_W + DIGIT_W + 2;
   localparam int CW   = $clog2(NDIG + 1);

   logic [FE_W:0]    a_q;
   logic [BW-1:0]    b_q;
   fe_t              acc_q;
   logic [CW-1:0]    cnt_q;
   logic [DIGIT_W-1:0] digit;
   logic [WX-1:0]    x;
   logic [WX-FE_W-1:0] hi;
   logic [FE_W:0]    t1, t2;
   fe_t              acc_nx;

   // Horner step over base 2^DIGIT_W, most significant digit first
   always_comb begin
      digit  = b_q[BW-1 -: DIGIT_W];
      x      = WX'({acc_q, {DIGIT_W{1'b0}}}) + WX'(a_q) * WX'(digit);
      hi     = x[WX-1:FE_W];
      t1     = {1'b0, x[FE_W-1:0]} + (FE_W+1)'(hi) * (FE_W+1)'(5);
      t2     = {1'b0, t1[FE_W-1:0]} + (t1[FE_W] ? (FE_W+1)'(5) : '0);
      acc_nx = red_once(t2);
   end

   assign y = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         acc_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            a_q   <= a;
            b_q   <= BW'(b);
            acc_q <= '0;
            cnt_q <= CW'(NDIG);
            busy  <= 1'b1;
         end else if (busy) begin
            acc_q <= acc_nx;
            b_q   <= b_q << DIGIT_W;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/poly_tag_engine.sv
module poly_tag_engine import poly_pkg::*; #(
   parameter int FIFO_DEPTH = 8,
   parameter int DIGIT_W    = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [127:0] in_data,
   input  logic         in_last,
   input  logic [4:0]   in_bytes,
   output logic         tag_valid,
   output logic [127:0] tag
);
   localparam int ENTRY_W = BLK_W + 1;

   generate
      if (DIGIT_W < 1 || DIGIT_W > 32) begin : g_bad_digit
         $error("poly_tag_engine: DIGIT_W must lie in 1..32");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("poly_tag_engine: FIFO_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   phase_e       phase_q;
   logic [127:0] r_q, s_q, tag_q;
   fe_t          r2_q;
   fe_t          acc_q [2];
   logic         r2_ok_q, wsel_q, rr_q, op_sq_q, op_lane_q, tag_valid_q;

   logic [ENTRY_W-1:0] head [2];
   logic [ENTRY_W-1:0] wentry, head_sel;
   logic [1:0]   empty, full, push, pop;
   logic         accept, sq_start, issue, sel, finish;
   logic [127:0] r_cl;
   logic [FE_W:0] mul_a;
   fe_t          mul_b, mul_y, acc_sum;
   logic         mul_busy, mul_done;

   assign in_ready = (phase_q == PH_R) || (phase_q == PH_S) ||
                     ((phase_q == PH_MSG) && !full[wsel_q]);
   assign accept   = in_valid && in_ready;
   assign r_cl     = in_data & R_CLAMP;
   assign wentry   = {in_last, pad_block(in_data, in_last ? in_bytes : 5'd16)};
   assign sq_start = accept && (phase_q == PH_R);

   // lane pick: alternate, fall back to the other lane when one is dry
   assign sel      = !empty[rr_q] ? rr_q : ~rr_q;
   assign issue    = r2_ok_q && !mul_busy && !mul_done && (empty != 2'b11);
   assign head_sel = head[sel];

   generate
      for (genvar gl = 0; gl < 2; gl++) begin : g_lane
         assign push[gl] = accept && (phase_q == PH_MSG) && (wsel_q == gl[0]);
         assign pop[gl]  = issue && (sel == gl[0]);
         poly_lane_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[gl]),
            .wdata (wentry),
            .pop   (pop[gl]),
            .rdata (head[gl]),
            .empty (empty[gl]),
            .full  (full[gl])
         );
      end
   endgenerate

   // ending block of the message steps with r, all others with r^2
   always_comb begin
      if (sq_start) begin
         mul_a = {3'b0, r_cl};
         mul_b = {2'b0, r_cl};
      end else begin
         mul_a = {1'b0, acc_q[sel]} + {2'b0, head_sel[BLK_W-1:0]};
         mul_b = head_sel[BLK_W] ? {2'b0, r_q} : r2_q;
      end
   end

   poly_modmul #(.DIGIT_W(DIGIT_W)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sq_start || issue),
      .a     (mul_a),
      .b     (mul_b),
      .busy  (mul_busy),
      .done  (mul_done),
      .y     (mul_y)
   );

   assign finish  = (phase_q == PH_CLOSED) && (empty == 2'b11) &&
                    !mul_busy && !mul_done && r2_ok_q;
   assign acc_sum = red_once({1'b0, acc_q[0]} + {1'b0, acc_q[1]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_R;
         r_q         <= '0;
         s_q         <= '0;
         r2_q        <= '0;
         r2_ok_q     <= 1'b0;
         wsel_q      <= 1'b0;
         rr_q        <= 1'b0;
         op_sq_q     <= 1'b0;
         op_lane_q   <= 1'b0;
         tag_q       <= '0;
         tag_valid_q <= 1'b0;
         for (int i = 0; i < 2; i++) acc_q[i] <= '0;
      end else begin
         tag_valid_q <= finish;
         if (accept) begin
            case (phase_q)
               PH_R: begin
                  r_q     <= r_cl;
                  op_sq_q <= 1'b1;
                  phase_q <= PH_S;
               end
               PH_S: begin
                  s_q     <= in_data;
                  phase_q <= PH_MSG;
               end
               PH_MSG: begin
                  wsel_q <= ~wsel_q;
                  if (in_last) phase_q <= PH_CLOSED;
               end
               default: phase_q <= phase_q;
            endcase
         end
         if (issue) begin
            rr_q      <= ~sel;
            op_sq_q   <= 1'b0;
            op_lane_q <= sel;
         end
         if (mul_done) begin
            if (op_sq_q) begin
               r2_q    <= mul_y;
               r2_ok_q <= 1'b1;
            end else begin
               acc_q[op_lane_q] <= mul_y;
            end
         end
         if (finish) begin
            tag_q   <= acc_sum[127:0] + s_q;
            phase_q <= PH_R;
            r2_ok_q <= 1'b0;
            wsel_q  <= 1'b0;
            rr_q    <= 1'b0;
            for (int i = 0; i < 2; i++) acc_q[i] <= '0;
         end
      end
   end

   assign tag_valid = tag_valid_q;
   assign tag       = tag_q;
endmodule

// File: rtl/poly_tag_engine_chk.sv
module poly_tag_engine_chk import poly_pkg::*; (
   input logic   clk,
   input logic   rst_n,
   input logic   in_valid,
   input logic   in_ready,
   input logic   in_last,
   input logic   tag_valid,
   input phase_e phase_q
);
   // R6: strobe lasts one cycle
   a_r6_tag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |=> !tag_valid);

   // R6: next packet may enter while the tag is shown
   a_r6_ready_with_tag: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |-> in_ready);

   // R6: input closes after the ending word
   a_r6_closed_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last && phase_q == PH_MSG) |=> !in_ready);

   // R3: a tag only follows a closed message
   a_r3_tag_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tag_valid) |-> $past(phase_q) == PH_CLOSED);

   // R7: key words are never refused
   a_r7_key_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_S) |-> in_ready);
endmodule

bind poly_tag_engine poly_tag_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .tag_valid (tag_valid),
   .phase_q   (phase_q)
);

// File: tb/poly_tag_engine_bench.sv
module poly_tag_engine_bench;
   localparam int DEPTH = 8;
   localparam logic [129:0] PM = {2'b11, {124{1'b1}}, 4'b1011};
   localparam logic [127:0] CLMP = 128'h0ffffffc0ffffffc0ffffffc0fffffff;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic         in_last = 1'b0;
   logic [4:0]   in_bytes = '0;
   logic         tag_valid;
   logic [127:0] tag;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [127:0] msg [0:31];

   always #2 clk = ~clk;

   poly_tag_engine #(.FIFO_DEPTH(DEPTH), .DIGIT_W(26)) u_poly_tag_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
      .tag_valid(tag_valid), .tag(tag)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [131:0] modp(input logic [131:0] v);
      logic [131:0] t;
      t = v;
      while (t >= {2'b0, PM}) t = t - {2'b0, PM};
      return t;
   endfunction

   function automatic logic [131:0] mulmod(input logic [131:0] a, input logic [131:0] b);
      logic [131:0] ar, br, res;
      ar  = modp(a);
      br  = modp(b);
      res = '0;
      for (int i = 129; i >= 0; i--) begin
         res = modp(res << 1);
         if (br[i]) res = modp(res + ar);
      end
      return res;
   endfunction

   // serial reference over msg[0..n-1]
   function automatic logic [127:0] model_tag(input logic [127:0] r_raw, input logic [127:0] s,
                                              input int n, input int lastlen);
      logic [131:0] h, m, r;
      logic [131:0] sum;
      r = {4'b0, r_raw & CLMP};
      h = '0;
      for (int i = 0; i < n; i++) begin
         m = '0;
         if (i == n - 1 && lastlen >= 1 && lastlen <= 15) begin
            for (int j = 0; j < lastlen; j++) m[8*j +: 8] = msg[i][8*j +: 8];
            m[8*lastlen] = 1'b1;
         end else begin
            m[127:0] = msg[i];
            m[128]   = 1'b1;
         end
         h = mulmod(h + m, r);
      end
      sum = h + {4'b0, s};
      return sum[127:0];
   endfunction

   function automatic logic [127:0] mkword(input int seed, input int i);
      logic [31:0] a;
      logic [127:0] w;
      a = 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h85EBCA6B + 32'h1234567;
      for (int k = 0; k < 4; k++) begin
         a = a * 32'h41C64E6D + 32'h3039;
         w[32*k +: 32] = a ^ (a >> 13);
      end
      return w;
   endfunction

   task automatic fill(input int seed, input int n);
      for (int i = 0; i < n; i++) msg[i] = mkword(seed, i);
   endtask

   task automatic send_word(input logic [127:0] d, input bit last, input logic [4:0] nb,
                            inout int stalls);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      in_bytes = nb;
      while (!in_ready) begin
         stalls++;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // sends one packet, checks handshake rules (R6) and returns the tag
   task automatic run_packet(input logic [127:0] r, input logic [127:0] s, input int n,
                             input logic [4:0] lastnb, input logic [4:0] midnb,
                             output logic [127:0] got, output int stalls, output int early);
      int cyc;
      stalls = 0;
      early  = 0;
      send_word(r, 1'b0, 5'd16, stalls);
      send_word(s, 1'b0, 5'd16, stalls);
      for (int i = 0; i < n; i++) begin
         send_word(msg[i], i == n - 1, (i == n - 1) ? lastnb : midnb, stalls);
         if (i == 2*DEPTH - 1) early = stalls;
      end
      check(in_ready == 1'b0, "R6", "in_ready after last word", {127'b0, in_ready}, 128'd0);
      cyc = 0;
      while (!tag_valid && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      check(tag_valid == 1'b1, "R6", "tag_valid arrives", {127'b0, tag_valid}, 128'd1);
      got = tag;
      check(in_ready == 1'b1, "R6", "in_ready with tag", {127'b0, in_ready}, 128'd1);
      @(negedge clk);
      check(tag_valid == 1'b0, "R6", "tag_valid one cycle", {127'b0, tag_valid}, 128'd0);
   endtask

   task automatic t_reset;
      check(in_ready == 1'b1, "R1", "in_ready after reset", {127'b0, in_ready}, 128'd1);
      check(tag_valid == 1'b0, "R1", "tag_valid after reset", {127'b0, tag_valid}, 128'd0);
   endtask

   task automatic t_known_vector;
      string str;
      logic [127:0] got;
      int st, ea;
      str = "Cryptographic Forum Research Group";
      for (int i = 0; i < 3; i++) msg[i] = '0;
      for (int i = 0; i < 34; i++) msg[i/16][8*(i%16) +: 8] = str[i];
      run_packet(128'ha806d542fe52447f336d555778bed685, 128'h1bf54941aff6bf4afdb20dfb8a800301,
                 3, 5'd2, 5'd16, got, st, ea);
      check(got == 128'ha927010caf8b2bc2c6365130c11d06a8, "R4", "known vector tag",
            got, 128'ha927010caf8b2bc2c6365130c11d06a8);
   endtask

   task automatic t_full_blocks;
      int counts [5] = '{1, 2, 3, 4, 7};
      logic [127:0] got, exp, r, s;
      int st, ea;
      foreach (counts[k]) begin
         fill(10 + k, counts[k]);
         r = mkword(100 + k, 0);
         s = mkword(200 + k, 1);
         exp = model_tag(r, s, counts[k], 16);
         run_packet(r, s, counts[k], 5'd16, 5'd16, got, st, ea);
         check(got == exp, "R3", $sformatf("full blocks n=%0d", counts[k]), got, exp);
      end
   endtask

   task automatic t_partial;
      int lens [4] = '{1, 5, 15, 0};
      int nbl  [4] = '{1, 2, 3, 4};
      logic [127:0] got, exp, r, s;
      int st, ea;
      foreach (lens[k]) begin
         fill(30 + k, nbl[k]);
         r = mkword(300 + k, 2);
         s = mkword(400 + k, 3);
         exp = model_tag(r, s, nbl[k], (lens[k] == 0) ? 16 : lens[k]);
         run_packet(r, s, nbl[k], 5'(lens[k]), 5'd16, got, st, ea);
         check(got == exp, "R4", $sformatf("last len=%0d n=%0d", lens[k], nbl[k]), got, exp);
      end
   endtask

   task automatic t_clamp;
      logic [127:0] g1, g2, exp, s;
      int st, ea;
      fill(50, 3);
      s = mkword(51, 0);
      exp = model_tag({128{1'b1}}, s, 3, 16);
      run_packet({128{1'b1}}, s, 3, 5'd16, 5'd16, g1, st, ea);
      run_packet(CLMP, s, 3, 5'd16, 5'd16, g2, st, ea);
      check(g1 == exp, "R2", "unclamped r tag", g1, exp);
      check(g1 == g2, "R2", "clamp bits have no effect", g1, g2);
   endtask

   task automatic t_mid_bytes;
      logic [127:0] got, exp, r, s;
      int st, ea;
      fill(60, 5);
      r = mkword(61, 0);
      s = mkword(62, 0);
      exp = model_tag(r, s, 5, 16);
      run_packet(r, s, 5, 5'd16, 5'd3, got, st, ea);
      check(got == exp, "R5", "in_bytes on non-last words", got, exp);
   endtask

   task automatic t_backpressure;
      logic [127:0] got, exp, r, s;
      int st, ea;
      fill(70, 24);
      r = mkword(71, 0);
      s = mkword(72, 0);
      exp = model_tag(r, s, 24, 9);
      run_packet(r, s, 24, 5'd9, 5'd16, got, st, ea);
      check(ea == 0, "R7", "no stall while lanes have room", 128'(ea), 128'd0);
      check(st > 0, "R7", "stalls once lanes fill", 128'(st), 128'd1);
      check(got == exp, "R7", "tag under backpressure", got, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_known_vector();
      t_full_blocks();
      t_partial();
      t_clamp();
      t_mid_bytes();
      t_backpressure();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule